// File: doc/BRIEF.md
# CAN Transmit Request Scheduler

This block sits between the software-visible mailbox controls of a CAN controller and its protocol engine. Software raises or withdraws a transmit request per mailbox and gives each mailbox a 5-bit priority that it may rewrite at any moment. The block chooses which pending mailbox the engine should send next. It holds that choice while a frame is on the bus and records the outcome as an acknowledge flag or an abort-acknowledge flag.

A frame that loses arbitration or meets an error stays pending, so it is retried automatically. A remote frame received for a mailbox enabled for automatic reply raises that mailbox's request with no software action. A withdrawal aimed at the mailbox currently on the bus is held until the frame ends. It takes effect only if the frame fails. Self-test loopback runs inside the engine: there, a frame the engine receives back counts as an ordinary successful send, so the scheduler works the same way in both modes.

Top module: `can_tx_sched`

## Requirements
- R1: After reset the request, acknowledge and abort-acknowledge vectors are all zero and `sel_vld` is 0.
- R2: A 1 on `req_set[i]`, or on `rmt_hit[i]` while `arp_en[i]` is 1, makes request bit `i` of `trq` read 1 after the next clock edge. `rmt_hit[i]` while `arp_en[i]` is 0 has no effect.
- R3: When no frame is locked, `sel_vld` is 1 exactly when some bit of `trq` is 1. `sel_idx` is then the pending mailbox whose priority field `prio[i*5 +: 5]` is numerically largest. Ties go to the largest mailbox index. The selection follows priority changes in the same cycle.
- R4: A pulse on `eng_start` while `sel_vld` is 1 and no frame is locked locks `sel_idx`. Until a completion pulse arrives, `sel_vld` stays 1 and `sel_idx` stays fixed, whatever happens to requests or priorities.
- R5: `eng_ok` on a locked frame sets `ack` for that mailbox and clears its `trq` bit after the edge. A `req_set` to that mailbox in the same cycle leaves it pending again.
- R6: `eng_lost` or `eng_err` on a locked frame (without `eng_ok`) releases the lock and keeps the mailbox pending, so that it can be selected again. `eng_ok` takes precedence when both are asserted.
- R7: `req_clr[i]` on a pending mailbox that is not locked and has no `req_set[i]` in the same cycle clears `trq[i]` and sets `abt[i]`. On a mailbox that is not pending it does nothing.
- R8: `req_clr` for the locked mailbox (including one in the cycle of `eng_start`) is deferred. If the frame then succeeds, only `ack` is set. If it fails, `trq` is cleared and `abt` is set.
- R9: `ack_clr[i]` and `abt_clr[i]` clear the matching flag (write one to clear). A flag set in the same cycle stays set.
- R10: Completion pulses that arrive while no frame is locked are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | NMB | Per-mailbox transmit request set strobe |
| req_clr | input | NMB | Per-mailbox transmit request withdrawal strobe |
| rmt_hit | input | NMB | Remote frame received for mailbox |
| arp_en | input | NMB | Automatic reply enable per mailbox |
| ack_clr | input | NMB | Write-one-to-clear for `ack` |
| abt_clr | input | NMB | Write-one-to-clear for `abt` |
| prio | input | NMB*PW | Packed per-mailbox priorities, mailbox i at bits i*PW+:PW |
| eng_start | input | 1 | Engine begins a frame for `sel_idx` |
| eng_ok | input | 1 | Locked frame sent successfully |
| eng_lost | input | 1 | Locked frame lost arbitration |
| eng_err | input | 1 | Locked frame ended in error |
| sel_idx | output | $clog2(NMB) | Mailbox to send |
| sel_vld | output | 1 | `sel_idx` is meaningful |
| trq | output | NMB | Pending transmit requests |
| ack | output | NMB | Transmission acknowledge flags |
| abt | output | NMB | Abort acknowledge flags |

## Verification
The bench goes after equal priorities, where a design that scanned from the low end would pick the smaller mailbox. It rewrites priorities and raises new requests mid-frame, which a design that re-arbitrated during a frame would answer by moving `sel_idx` under the engine. It withdraws the locked mailbox and then ends the frame both ways. A design that honoured the withdrawal at once would report an abort for a frame that went out, or would lose the abort when the frame failed. Stray completion pulses while idle, and set/clear collisions on the flags, catch designs that act on unlocked feedback or let a clear beat a new event.

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
  parameter int NMB = 8,
  parameter int PW  = 5,
  localparam int IW = (NMB > 1) ? $clog2(NMB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NMB-1:0]    req_set,
  input  logic [NMB-1:0]    req_clr,
  input  logic [NMB-1:0]    rmt_hit,
  input  logic [NMB-1:0]    arp_en,
  input  logic [NMB-1:0]    ack_clr,
  input  logic [NMB-1:0]    abt_clr,
  input  logic [NMB*PW-1:0] prio,
  input  logic              eng_start,
  input  logic              eng_ok,
  input  logic              eng_lost,
  input  logic              eng_err,
  output logic [IW-1:0]     sel_idx,
  output logic              sel_vld,
  output logic [NMB-1:0]    trq,
  output logic [NMB-1:0]    ack,
  output logic [NMB-1:0]    abt
);

  logic          busy, apend;
  logic [IW-1:0] lock_idx, best_idx;
  logic [PW-1:0] best_p;
  logic          any;

  always_comb begin
    any = 1'b0;
    best_idx = '0;
    best_p = '0;
    for (int i = 0; i < NMB; i++)
      if (trq[i] && (!any || prio[i*PW +: PW] >= best_p)) begin
        any = 1'b1;
        best_idx = IW'(i);
        best_p = prio[i*PW +: PW];
      end
  end

  assign sel_vld = busy | any;
  assign sel_idx = busy ? lock_idx : best_idx;

  logic          start, fin, fail;
  logic [IW-1:0] tgt;
  logic          locked;
  logic [NMB-1:0] newset, lockmask, cancel, done_clr, ack_set, abt_set;

  assign start  = !busy && eng_start && any;
  assign fin    = busy && (eng_ok || eng_lost || eng_err);
  assign fail   = fin && !eng_ok;
  assign tgt    = busy ? lock_idx : best_idx;
  assign locked = busy || start;
  assign newset = req_set | (rmt_hit & arp_en);

  always_comb begin
    lockmask = '0;
    done_clr = '0;
    ack_set  = '0;
    if (locked) lockmask[tgt] = 1'b1;
    cancel = req_clr & trq & ~newset & ~lockmask;
    abt_set = cancel;
    if (fin && eng_ok) begin
      done_clr[lock_idx] = 1'b1;
      ack_set[lock_idx]  = 1'b1;
    end else if (fail && (apend || req_clr[lock_idx])) begin
      done_clr[lock_idx] = 1'b1;
      abt_set[lock_idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trq <= '0;
      ack <= '0;
      abt <= '0;
      busy <= 1'b0;
      apend <= 1'b0;
      lock_idx <= '0;
    end else begin
      trq <= (trq & ~(cancel | done_clr)) | newset;
      ack <= (ack & ~ack_clr) | ack_set;
      abt <= (abt & ~abt_clr) | abt_set;
      if (start) begin
        busy <= 1'b1;
        lock_idx <= best_idx;
        apend <= req_clr[best_idx];
      end else if (fin) begin
        busy <= 1'b0;
        apend <= 1'b0;
      end else if (busy) begin
        apend <= apend | req_clr[lock_idx];
      end
    end
  end

  a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(eng_ok || eng_lost || eng_err)) |=> (sel_vld && sel_idx == $past(sel_idx)));

  a_r5_ok_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_ok) |=> ack[$past(lock_idx)]);

  a_r8_ok_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_ok && !abt[lock_idx]) |=> !abt[$past(lock_idx)]);

  a_r6_retry_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_ok && (eng_lost || eng_err) && !apend && !req_clr[lock_idx])
      |=> (trq[$past(lock_idx)] && sel_vld));

  a_r2_sel_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> trq[sel_idx]);

  for (genvar g = 0; g < NMB; g++) begin : g_chk
    a_r3_max_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trq[g]) |-> (prio[g*PW +: PW] <= prio[sel_idx*PW +: PW]));
  end

endmodule

// File: tb/sim_can_tx_sched.sv
module sim_can_tx_sched;
  localparam int N = 8, PW = 5, IW = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_set = 0, req_clr = 0, rmt_hit = 0, arp_en = 0, ack_clr = 0, abt_clr = 0;
  logic [N*PW-1:0] prio = 0;
  logic eng_start = 0, eng_ok = 0, eng_lost = 0, eng_err = 0;
  logic [IW-1:0] sel_idx;
  logic sel_vld;
  logic [N-1:0] trq, ack, abt;

  can_tx_sched #(.NMB(N), .PW(PW)) u0 (.*);

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  logic [N-1:0] mtrq, mack, mabt;
  logic mbusy, mapend;
  logic [IW-1:0] mlock;

  function automatic int mbest(input logic [N-1:0] t, input logic [N*PW-1:0] p);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (t[i] && (b < 0 || p[i*PW +: PW] >= p[b*PW +: PW])) b = i;
    return b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mtrq = 0; mack = 0; mabt = 0; mbusy = 0; mapend = 0; mlock = 0;
    end else begin
      logic [N-1:0] ns, nt, na, nb;
      int b, tg;
      bit lk, fin;
      b  = mbest(mtrq, prio);
      ns = req_set | (rmt_hit & arp_en);
      lk = mbusy || (eng_start && b >= 0);
      tg = mbusy ? int'(mlock) : b;
      nt = mtrq; na = mack & ~ack_clr; nb = mabt & ~abt_clr;
      for (int i = 0; i < N; i++)
        if (req_clr[i] && mtrq[i] && !ns[i] && !(lk && i == tg)) begin
          nt[i] = 0; nb[i] = 1;
        end
      fin = mbusy && (eng_ok || eng_lost || eng_err);
      if (fin && eng_ok) begin nt[mlock] = 0; na[mlock] = 1; end
      else if (fin && (mapend || req_clr[mlock])) begin nt[mlock] = 0; nb[mlock] = 1; end
      nt = nt | ns;
      if (!mbusy && eng_start && b >= 0) begin
        mbusy = 1; mlock = IW'(b); mapend = req_clr[b];
      end else if (fin) begin
        mbusy = 0; mapend = 0;
      end else if (mbusy) mapend = mapend | req_clr[mlock];
      mtrq = nt; mack = na; mabt = nb;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic look();
    int b = mbest(mtrq, prio);
    chk("R2 trq", 32'(trq), 32'(mtrq));
    chk("R5 ack", 32'(ack), 32'(mack));
    chk("R7 abt", 32'(abt), 32'(mabt));
    chk("R3 sel_vld", 32'(sel_vld), 32'(mbusy || b >= 0));
    if (mbusy) chk("R4 sel_idx", 32'(sel_idx), 32'(mlock));
    else if (b >= 0) chk("R3 sel_idx", 32'(sel_idx), 32'(b));
  endtask

  task automatic step();
    @(negedge clk);
    look();
    req_set = 0; req_clr = 0; rmt_hit = 0; ack_clr = 0; abt_clr = 0;
    eng_start = 0; eng_ok = 0; eng_lost = 0; eng_err = 0;
  endtask

  task automatic setp(input int i, input int v);
    prio[i*PW +: PW] = PW'(v);
  endtask

  initial begin
    #(5 * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset trq", 32'(trq), 0);
    chk("R1 reset ack", 32'(ack), 0);
    chk("R1 reset abt", 32'(abt), 0);
    chk("R1 reset vld", 32'(sel_vld), 0);

    // R2 remote hit without auto-reply enable is ignored
    rmt_hit = 8'h10; step();
    chk("R2 rmt ignored", 32'(trq), 0);
    arp_en = 8'h10; rmt_hit = 8'h10; step();
    chk("R2 rmt reply", 32'(trq), 32'h10);

    // R3 priority and tie
    setp(2, 5); setp(5, 5); setp(1, 9); setp(4, 1);
    req_set = 8'h26; step();
    chk("R3 max prio", 32'(sel_idx), 1);
    setp(1, 3); step();
    chk("R3 tie high idx", 32'(sel_idx), 5);

    // R4 lock, then R6 retry on lost
    eng_start = 1; step();
    setp(4, 31); req_set = 8'h80; step();
    chk("R4 locked idx", 32'(sel_idx), 5);
    eng_lost = 1; step();
    chk("R6 still pending", 32'(trq[5]), 1);
    chk("R6 reselect", 32'(sel_idx), 4);

    // R8 deferred abort, success path
    eng_start = 1; req_clr = 8'h10; step();
    eng_ok = 1; step();
    chk("R8 ok acks", 32'(ack[4]), 1);
    chk("R8 ok no abt", 32'(abt[4]), 0);

    // R8 deferred abort, failure path
    setp(7, 30); step();
    eng_start = 1; step();
    req_clr = 8'h80; step();
    chk("R8 deferred", 32'(trq[7]), 1);
    eng_err = 1; step();
    chk("R8 fail aborts", 32'(abt[7]), 1);
    chk("R8 fail drops", 32'(trq[7]), 0);

    // R7 idle withdrawal, R10 stray completion
    req_clr = 8'h04; step();
    chk("R7 abort idle", 32'(abt[2]), 1);
    req_clr = 8'h01; step();
    chk("R7 nonpending", 32'(abt[0]), 0);
    eng_ok = 1; step();
    chk("R10 stray ok", 32'(ack & 8'h22), 0);

    // R9 clear and set-wins
    ack_clr = 8'h10; abt_clr = 8'h04; step();
    chk("R9 ack cleared", 32'(ack[4]), 0);
    chk("R9 abt cleared", 32'(abt[2]), 0);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 7) == 0)
        for (int i = 0; i < N; i++) setp(i, $urandom_range(0, 31));
      req_set = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      req_clr = ($urandom_range(0, 5) == 0) ? N'($urandom) & N'($urandom) : '0;
      rmt_hit = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
      arp_en  = ($urandom_range(0, 31) == 0) ? N'($urandom) : arp_en;
      ack_clr = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      abt_clr = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      eng_start = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 3) == 0) begin
        eng_ok   = ($urandom_range(0, 1) == 0);
        eng_lost = ($urandom_range(0, 2) == 0);
        eng_err  = ($urandom_range(0, 2) == 0);
      end
      step();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule